// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the raster timing for a display. It runs on the pixel clock. A pixel counter and a line counter sweep the frame, and a set of programmed last-position values is compared against them. The outputs are the display-enable window, the horizontal and vertical sync pulses, a composite sync meant for sync-on-video, and a one-pixel line-fetch strobe. The strobe warns the pixel path a set number of pixels before each line ends.

Every timing value is written as a zero-based position, which is the count minus one. The horizontal and vertical totals give the last pixel and the last line. The active values give the last visible pixel and line. A sync start value is the last position before its pulse, so the pulse covers the positions after start, up to and including end.

Timing values go into staging registers. They reach the comparators only when the frame wraps, or at any time while the generator is stopped, so a rewrite in the middle of a frame cannot distort the current frame. The control, sync and display registers act on the next cycle. The sync stage can invert each pulse and can suppress each one for power saving. A display-off bit blanks the video while the timing keeps running.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset both counters are 0, the generator is stopped, every register is 0, and disp_en, hsync, vsync, csync and line_fetch are all 0.
- R2: While running, h_count steps by one per clock. After h_count reaches the horizontal total it returns to 0 and v_count steps by one. After v_count reaches the vertical total at the end of a line, v_count returns to 0.
- R3: While control bit 0 (address 0, the run enable) is 0, both counters hold their values. The raw syncs, disp_en and line_fetch are inactive.
- R4: disp_en is 1 exactly when the generator runs, control bit 1 (refresh enable) is 1, the display is not switched off, h_count ≤ active width value (address 4) and v_count ≤ active height value (address 8).
- R5: The raw hsync is active when hsync start (address 5) < h_count ≤ hsync end (address 6). The raw vsync is active when vsync start (address 9) < v_count ≤ vsync end (address 10). Both raw syncs are active high.
- R6: line_fetch is 1 for exactly those cycles in which the generator runs and h_count equals the fetch position (address 11).
- R7: In the sync register (address 2), bit 3 inverts hsync and bit 4 inverts vsync.
- R8: In the sync register, bit 5 suppresses hsync, bit 6 suppresses vsync and bit 1 suppresses both. A suppressed sync sits at its inactive level after polarity, which is the value of its inversion bit.
- R9: csync equals (raw hsync OR raw vsync) when sync bit 0 is 1 and sync bit 1 is 0. Otherwise csync is 0.
- R10: Display register (address 1) bit 1 forces disp_en to 0. The counters and syncs keep running.
- R11: Timing registers (horizontal total at address 3, vertical total at address 7, and addresses 4–6 and 8–11) take effect in the first cycle of the next frame. While the generator is stopped they take effect on the cycle after the write. Control, sync and display writes take effect on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register index |
| wr_data | input | CW | Register write value |
| h_count | output | CW | Current pixel position in the line |
| v_count | output | CW | Current line in the frame |
| disp_en | output | 1 | Active video window |
| hsync | output | 1 | Horizontal sync after polarity and suppression |
| vsync | output | 1 | Vertical sync after polarity and suppression |
| csync | output | 1 | Composite sync for sync-on-video |
| line_fetch | output | 1 | Early line strobe |

## Verification
The bench programs a frame of 10 pixels by 5 lines. Two full frames are compared against an independent model at every cycle, which shows that the counter wrap, the active window, the sync intervals and the fetch strobe line up with one another.

A table of sync-register values covers plain, inverted, suppressed-per-signal, suppressed-both and composite settings. Each setting is sampled once where both raw syncs are active and once where both are idle. This separates inversion from suppression, and per-signal suppression from suppressing both.

Directed tests cover the following:
- display-off and refresh-disable blanking while the syncs keep running;
- a width change written mid-frame, which must not appear until the next frame;
- stopping the generator, which must freeze both counters.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] h_count,
  output logic [CW-1:0] v_count,
  output logic          disp_en,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          line_fetch
);
  localparam int NT = 9;
  localparam int TBASE = 3;

  logic [1:0]    ctrl_q;
  logic          doff_q;
  logic [6:0]    sync_q;
  logic [CW-1:0] stage_q [NT];
  logic [CW-1:0] act_q   [NT];

  wire run = ctrl_q[0];
  wire [CW-1:0] htot = act_q[0], hact = act_q[1], hss = act_q[2], hse = act_q[3];
  wire [CW-1:0] vtot = act_q[4], vact = act_q[5], vss = act_q[6], vse = act_q[7];
  wire [CW-1:0] fpos = act_q[8];

  wire h_last = h_count >= htot;
  wire v_last = v_count >= vtot;
  wire frame_load = !run || (h_last && v_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      doff_q <= 1'b0;
      sync_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(0)) ctrl_q <= wr_data[1:0];
      if (wr_addr == AW'(1)) doff_q <= wr_data[1];
      if (wr_addr == AW'(2)) sync_q <= wr_data[6:0];
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_treg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[i] <= '0;
        act_q[i]   <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(TBASE + i)) stage_q[i] <= wr_data;
        if (frame_load) act_q[i] <= stage_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_count <= '0;
      v_count <= '0;
    end else if (run) begin
      if (h_last) begin
        h_count <= '0;
        v_count <= v_last ? '0 : v_count + 1'b1;
      end else begin
        h_count <= h_count + 1'b1;
      end
    end
  end

  wire hs_raw = run && h_count > hss && h_count <= hse;
  wire vs_raw = run && v_count > vss && v_count <= vse;

  assign disp_en    = run && ctrl_q[1] && !doff_q && h_count <= hact && v_count <= vact;
  assign line_fetch = run && h_count == fpos;
  assign hsync      = (sync_q[1] || sync_q[5]) ? sync_q[3] : (hs_raw ^ sync_q[3]);
  assign vsync      = (sync_q[1] || sync_q[6]) ? sync_q[4] : (vs_raw ^ sync_q[4]);
  assign csync      = sync_q[0] && !sync_q[1] && (hs_raw || vs_raw);
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [CW-1:0] h_count,
  input logic [CW-1:0] v_count,
  input logic [CW-1:0] htot,
  input logic [CW-1:0] vtot,
  input logic          doff_q,
  input logic [6:0]    sync_q,
  input logic          disp_en,
  input logic          hsync,
  input logic          vsync,
  input logic          line_fetch
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(h_count) && $stable(v_count)));
  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_count < htot) |=> h_count == CW'($past(h_count) + 1'b1));
  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_count >= htot) |=> h_count == '0);
  p_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_fetch |-> run);
  p_doff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    doff_q |-> !disp_en);
  p_hsupp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[1] || sync_q[5]) |-> hsync == sync_q[3]);
  p_vsupp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[1] || sync_q[6]) |-> vsync == sync_q[4]);
  p_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(h_count >= htot && v_count >= vtot)) |=> $stable(htot));
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .h_count(h_count), .v_count(v_count),
  .htot(htot), .vtot(vtot), .doff_q(doff_q), .sync_q(sync_q),
  .disp_en(disp_en), .hsync(hsync), .vsync(vsync), .line_fetch(line_fetch)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
  localparam int CW = 12;
  localparam int AW = 4;
  localparam time CLK_PERIOD = 10ns;

  // sync value [12:6], hs act/idle [5:4], vs act/idle [3:2], cs act/idle [1:0]
  localparam logic [12:0] SYNC_TBL [10] = '{
    {7'h00, 2'b10, 2'b10, 2'b00},
    {7'h08, 2'b01, 2'b10, 2'b00},
    {7'h10, 2'b10, 2'b01, 2'b00},
    {7'h18, 2'b01, 2'b01, 2'b00},
    {7'h20, 2'b00, 2'b10, 2'b00},
    {7'h28, 2'b11, 2'b10, 2'b00},
    {7'h40, 2'b10, 2'b00, 2'b00},
    {7'h02, 2'b00, 2'b00, 2'b00},
    {7'h1A, 2'b11, 2'b11, 2'b00},
    {7'h01, 2'b10, 2'b10, 2'b10}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] h_count, v_count;
  logic disp_en, hsync, vsync, csync, line_fetch;

  int checks = 0, fails = 0;
  int m_h = 0, m_v = 0;
  logic [1:0] m_ctrl = '0;
  logic m_doff = 1'b0;
  logic [6:0] m_sync = '0;
  int st [9];
  int ac [9];

  raster_timing_gen #(.CW(CW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .h_count(h_count), .v_count(v_count), .disp_en(disp_en), .hsync(hsync),
    .vsync(vsync), .csync(csync), .line_fetch(line_fetch)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit load;
    load = !m_ctrl[0] || (m_h == ac[0] && m_v == ac[4]);
    if (m_ctrl[0]) begin
      if (m_h == ac[0]) begin
        m_h = 0;
        m_v = (m_v == ac[4]) ? 0 : m_v + 1;
      end else m_h++;
    end
    if (load) for (int i = 0; i < 9; i++) ac[i] = st[i];
  endtask

  function automatic int expect_all();
    bit run, hr, vr, de, hs, vs, cs, pf;
    run = m_ctrl[0];
    hr = run && m_h > ac[2] && m_h <= ac[3];
    vr = run && m_v > ac[6] && m_v <= ac[7];
    de = run && m_ctrl[1] && !m_doff && m_h <= ac[1] && m_v <= ac[5];
    hs = (m_sync[1] || m_sync[5]) ? m_sync[3] : (hr ^ m_sync[3]);
    vs = (m_sync[1] || m_sync[6]) ? m_sync[4] : (vr ^ m_sync[4]);
    cs = m_sync[0] && !m_sync[1] && (hr || vr);
    pf = run && m_h == ac[8];
    return (m_h << 20) | (m_v << 8) | {de, hs, vs, cs, pf};
  endfunction

  function automatic int actual_all();
    return (int'(h_count) << 20) | (int'(v_count) << 8) |
           {disp_en, hsync, vsync, csync, line_fetch};
  endfunction

  task automatic check_all(input string tag);
    check(tag, actual_all(), expect_all());
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    step();
    wr_en = 1'b0;
    case (a)
      0: m_ctrl = d[1:0];
      1: m_doff = d[1];
      2: m_sync = d[6:0];
      default: if (a >= 3 && a <= 11) st[a-3] = d;
    endcase
  endtask

  task automatic go_to(input int h, input int v, input string tag);
    for (int n = 0; n < 200 && !(m_h == h && m_v == v); n++) begin
      @(negedge clk);
      step();
      check_all(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) begin st[i] = 0; ac[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", actual_all(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step();
    check("R1 after release", actual_all(), 0);

    // h: total 9, active 5, sync after 6 up to 7; v: total 4, active 2, sync line 3; fetch at 8
    wr(3, 9); wr(4, 5); wr(5, 6); wr(6, 7);
    wr(7, 4); wr(8, 2); wr(9, 2); wr(10, 3); wr(11, 8);
    check("R3 stopped counters", {h_count, v_count}, 0);
    check_all("R3 R11 stopped programming");

    wr(0, 3);
    check_all("R2 start");
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      step();
      check_all("R2 R4 R5 R6 frame sweep");
    end
    go_to(9, 4, "R2 approach wrap");
    @(negedge clk);
    step();
    check("R2 frame wrap", {h_count, v_count}, 0);
    go_to(8, 1, "R6 approach");
    check("R6 fetch strobe", line_fetch, 1);
    @(negedge clk);
    step();
    check("R6 strobe one pixel", line_fetch, 0);

    foreach (SYNC_TBL[k]) begin
      wr(2, SYNC_TBL[k][12:6]);
      go_to(7, 3, "R7 R8 R9 sweep");
      check("R7 R8 hsync active pos", hsync, SYNC_TBL[k][5]);
      check("R7 R8 vsync active pos", vsync, SYNC_TBL[k][3]);
      check("R9 csync active pos", csync, SYNC_TBL[k][1]);
      go_to(0, 0, "R7 R8 R9 sweep");
      check("R7 R8 hsync idle pos", hsync, SYNC_TBL[k][4]);
      check("R7 R8 vsync idle pos", vsync, SYNC_TBL[k][2]);
      check("R9 csync idle pos", csync, SYNC_TBL[k][0]);
    end
    wr(2, 0);

    wr(1, 2);
    go_to(2, 1, "R10 sweep");
    check("R10 display off blanks", disp_en, 0);
    go_to(7, 1, "R10 sweep");
    check("R10 hsync keeps running", hsync, 1);
    wr(1, 0);
    go_to(2, 2, "R10 sweep");
    check("R10 display back on", disp_en, 1);

    wr(0, 1);
    go_to(3, 0, "R4 sweep");
    check("R4 refresh off blanks", disp_en, 0);
    wr(0, 3);

    go_to(2, 1, "R11 sweep");
    wr(4, 2);
    go_to(4, 1, "R11 sweep");
    check("R11 old width kept mid-frame", disp_en, 1);
    go_to(4, 0, "R11 sweep");
    check("R11 new width next frame", disp_en, 0);
    go_to(2, 1, "R11 sweep");
    check("R11 new width inside", disp_en, 1);

    go_to(8, 3, "R3 sweep");
    wr(0, 2);
    repeat (5) begin
      @(negedge clk);
      step();
      check_all("R3 hold sweep");
    end
    check("R3 counters frozen", {h_count, v_count}, {12'd9, 12'd3});
    check("R3 outputs idle", {disp_en, hsync, vsync, line_fetch}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule